// File: doc/BRIEF.md
# Vectored Interrupt Router

The router gathers a wide bank of edge-triggered interrupt vectors and turns them into per-core interrupt lines. A rising edge on any vector input latches a pending bit. A pending vector is delivered only when three things hold: its own enable bit is set, the global delivery switch is on, and its routing names a core that exists. Delivery raises one or more of the eight interrupt lines of that core. The lines are chosen per group of 32 vectors.

Software uses a plain register port with a selectable 32-bit or 64-bit access width. Through it, software reads the pending status and clears it by writing ones, sets the enables, and writes one routing byte per vector and one line-select byte per vector group. The route byte is read in one of two ways. In the default form it holds a node number and a core mask. In the alternative form it holds a binary core index. A control bit selects the form. Two further register banks are plain storage and have no effect on delivery. One is the node map. The other is the balancing bank.

Top module: `intr_router_top`

## Requirements
- R1: A 0-to-1 transition on `vec_in[v]` sets pending bit v at the next clock, whatever the enable and global switch are. A vector held high sets the bit once only, and does not set it again after it has been cleared.
- R2: Status is read and cleared at byte offset 0x1800. Vector v sits at bit v%32 of 32-bit word 0x1800+4*(v/32), which is the same as bit v%64 of the 64-bit word at 0x1800+8*(v/64). Writing a 1 clears the bit and writing a 0 leaves it unchanged. A rising edge in the same cycle as a clear of the same bit leaves the bit set.
- R3: Enable for vector v is bit v&31 of the word at 0x1600+4*(v>>5), and 1 means enabled. A vector drives an output only while it is both pending and enabled.
- R4: The route byte of vector v is bits [8*(v&3)+7 : 8*(v&3)] of the word at 0x1C00+4*(v>>2).
- R5: In the default route form, route bits [7:4] are a node number and bits [3:0] are a core mask. Only node 0 exists. Each set mask bit c targets core c. A nonzero node field or a zero mask targets no core.
- R6: When control bit 1 is set, the route byte is an unsigned core index. Indices of 4 and above target no core.
- R7: The line-select byte of group g = v>>5 is byte lane g&3 of the word at 0x14C0+4*(g>>2). Each set bit l drives line l of every targeted core. A zero byte drives nothing.
- R8: Control bit 0 at offset 0x1000 is the global switch. While it is clear, all outputs are low and pending bits still latch.
- R9: `core_irq[8*c+l]` is the OR over all qualifying vectors. It is registered, so it reflects the pending, enable, route and control state one clock after that state changes.
- R10: The node-map bank (eight words at 0x14A0) and the balancing bank (eight words at 0x1680) read back what was written and have no effect on the outputs.
- R11: A read returns data in `reg_rdata` with `reg_rvalid` high one cycle after `reg_rd`. In a 64-bit access, the low half maps to the addressed word and the high half maps to the next word. This holds for reads and for writes. Unmapped addresses read as zero and ignore writes.
- R12: After reset, all registers, pending bits and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_in | input | NVEC | Edge-triggered interrupt vector inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wide | input | 1 | 1 selects a 64-bit access (two consecutive words) |
| reg_addr | input | AW | Byte address; bits [1:0] ignored |
| reg_wdata | input | 64 | Write data; low half only for 32-bit access |
| reg_rdata | output | 64 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| core_irq | output | NCORE*NLINE | Interrupt lines, core c line l at bit NLINE*c+l |

## Verification
The hardest case to reach is a vector edge that arrives in the very clock cycle in which software writes a 1 to clear the same status bit. The bench reaches it by raising the vector and issuing the clearing write at the same falling edge, so both are seen at one rising edge. Other cases that need deliberate stimulus are a vector held high across a clear, which must not set its bit again, and routes to a node other than 0 or to a core index out of range. The bench drives these through the register port under both route forms. A behavioural model compares the line outputs on every cycle.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;

   // Byte offsets of the register banks
   localparam int unsigned OFF_CTRL    = 32'h1000;
   localparam int unsigned OFF_NODEMAP = 32'h14A0;
   localparam int unsigned OFF_LINEMAP = 32'h14C0;
   localparam int unsigned OFF_ENABLE  = 32'h1600;
   localparam int unsigned OFF_BALANCE = 32'h1680;
   localparam int unsigned OFF_STATUS  = 32'h1800;
   localparam int unsigned OFF_ROUTE   = 32'h1C00;

   localparam int unsigned WORD_BITS   = 32;
   localparam int unsigned ROUTE_BITS  = 8;
   localparam int unsigned LSEL_BITS   = 8;
   localparam int unsigned GROUP_SIZE  = 32;
   localparam int unsigned CTRL_BITS   = 2;

   // Control word bit positions
   localparam int unsigned CTRL_GLB    = 0;
   localparam int unsigned CTRL_CPUENC = 1;

   function automatic logic in_region(input int unsigned wa,
                                      input int unsigned base_wa,
                                      input int unsigned nwords);
      return (wa >= base_wa) && (wa < base_wa + nwords);
   endfunction

endpackage

// File: rtl/intr_cfg_word.sv
module intr_cfg_word #(
   parameter int unsigned W   = 32,
   parameter int unsigned WA  = 0,
   parameter int unsigned AWW = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           wide,
   input  logic [AWW-1:0] wa_lo,
   input  logic [AWW-1:0] wa_hi,
   input  logic [63:0]    wdata,
   output logic [W-1:0]   q
);

   logic hit_lo;
   logic hit_hi;
   logic unused_bits;

   assign hit_lo      = wr_en && (32'(wa_lo) == WA);
   assign hit_hi      = wr_en && wide && (32'(wa_hi) == WA);
   assign unused_bits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (hit_lo) q <= wdata[W-1:0];
      else if (hit_hi) q <= wdata[32 +: W];
   end

endmodule

// File: rtl/intr_regs.sv
module intr_regs
   import intr_router_pkg::*;
#(
   parameter int unsigned NVEC = 256,
   parameter int unsigned AW   = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic                       wide,
   input  logic [AW-1:0]              addr,
   input  logic [63:0]                wdata,
   input  logic [NVEC-1:0]            pend_i,
   output logic [63:0]                rdata_o,
   output logic                       rvalid_o,
   output logic [NVEC-1:0]            en_o,
   output logic [NVEC*ROUTE_BITS-1:0] route_o,
   output logic [(NVEC/GROUP_SIZE)*LSEL_BITS-1:0] lsel_o,
   output logic                       glb_en_o,
   output logic                       cpu_enc_o,
   output logic [NVEC-1:0]            clr_o
);

   localparam int unsigned AWW       = AW - 2;
   localparam int unsigned VEC_WORDS = NVEC / WORD_BITS;
   localparam int unsigned RT_WORDS  = NVEC * ROUTE_BITS / WORD_BITS;
   localparam int unsigned NGRP      = NVEC / GROUP_SIZE;
   localparam int unsigned LS_WORDS  = NGRP * LSEL_BITS / WORD_BITS;
   localparam int unsigned CTRL_WA   = OFF_CTRL / 4;
   localparam int unsigned NM_WA     = OFF_NODEMAP / 4;
   localparam int unsigned LS_WA     = OFF_LINEMAP / 4;
   localparam int unsigned EN_WA     = OFF_ENABLE / 4;
   localparam int unsigned BL_WA     = OFF_BALANCE / 4;
   localparam int unsigned ST_WA     = OFF_STATUS / 4;
   localparam int unsigned RT_WA     = OFF_ROUTE / 4;

   logic [AWW-1:0]       wa_lo;
   logic [AWW-1:0]       wa_hi;
   logic [NVEC-1:0]      nodemap_q;
   logic [NVEC-1:0]      balance_q;
   logic [CTRL_BITS-1:0] ctrl_q;
   logic [31:0]          rd_lo;
   logic [31:0]          rd_hi;
   logic                 unused_addr;

   assign wa_lo       = addr[AW-1:2];
   assign wa_hi       = wa_lo + 1'b1;
   assign unused_addr = ^addr[1:0];

   // Word-sized storage banks
   for (genvar i = 0; i < VEC_WORDS; i++) begin : g_vecw
      intr_cfg_word #(.W(32), .WA(EN_WA + i), .AWW(AWW)) u_en (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide(wide),
         .wa_lo(wa_lo), .wa_hi(wa_hi), .wdata(wdata), .q(en_o[i*32 +: 32]));
      intr_cfg_word #(.W(32), .WA(BL_WA + i), .AWW(AWW)) u_bal (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide(wide),
         .wa_lo(wa_lo), .wa_hi(wa_hi), .wdata(wdata), .q(balance_q[i*32 +: 32]));
      intr_cfg_word #(.W(32), .WA(NM_WA + i), .AWW(AWW)) u_nm (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide(wide),
         .wa_lo(wa_lo), .wa_hi(wa_hi), .wdata(wdata), .q(nodemap_q[i*32 +: 32]));

      // Write-one-to-clear strobes for the status word
      logic st_lo;
      logic st_hi;
      assign st_lo = wr_en && (32'(wa_lo) == ST_WA + i);
      assign st_hi = wr_en && wide && (32'(wa_hi) == ST_WA + i);
      assign clr_o[i*32 +: 32] = st_lo ? wdata[31:0] :
                                 st_hi ? wdata[63:32] : 32'd0;
   end

   for (genvar i = 0; i < RT_WORDS; i++) begin : g_rtw
      intr_cfg_word #(.W(32), .WA(RT_WA + i), .AWW(AWW)) u_rt (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide(wide),
         .wa_lo(wa_lo), .wa_hi(wa_hi), .wdata(wdata), .q(route_o[i*32 +: 32]));
   end

   for (genvar i = 0; i < LS_WORDS; i++) begin : g_lsw
      intr_cfg_word #(.W(32), .WA(LS_WA + i), .AWW(AWW)) u_ls (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide(wide),
         .wa_lo(wa_lo), .wa_hi(wa_hi), .wdata(wdata), .q(lsel_o[i*32 +: 32]));
   end

   intr_cfg_word #(.W(CTRL_BITS), .WA(CTRL_WA), .AWW(AWW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide(wide),
      .wa_lo(wa_lo), .wa_hi(wa_hi), .wdata(wdata), .q(ctrl_q));

   assign glb_en_o  = ctrl_q[CTRL_GLB];
   assign cpu_enc_o = ctrl_q[CTRL_CPUENC];

   // Read selection, one 32-bit word at a time
   function automatic logic [31:0] rd_sel(
      input int unsigned                    a,
      input logic [CTRL_BITS-1:0]           ctl,
      input logic [NVEC-1:0]                en,
      input logic [NVEC-1:0]                bal,
      input logic [NVEC-1:0]                nm,
      input logic [NVEC-1:0]                pnd,
      input logic [NVEC*ROUTE_BITS-1:0]     rt,
      input logic [NGRP*LSEL_BITS-1:0]      ls);
      logic [31:0] r;
      r = '0;
      if (a == CTRL_WA)                        r = 32'(ctl);
      else if (in_region(a, EN_WA, VEC_WORDS)) r = en[(a - EN_WA)*32 +: 32];
      else if (in_region(a, BL_WA, VEC_WORDS)) r = bal[(a - BL_WA)*32 +: 32];
      else if (in_region(a, NM_WA, VEC_WORDS)) r = nm[(a - NM_WA)*32 +: 32];
      else if (in_region(a, ST_WA, VEC_WORDS)) r = pnd[(a - ST_WA)*32 +: 32];
      else if (in_region(a, RT_WA, RT_WORDS))  r = rt[(a - RT_WA)*32 +: 32];
      else if (in_region(a, LS_WA, LS_WORDS))  r = ls[(a - LS_WA)*32 +: 32];
      return r;
   endfunction

   always_comb begin
      rd_lo = rd_sel(32'(wa_lo), ctrl_q, en_o, balance_q, nodemap_q, pend_i,
                     route_o, lsel_o);
      rd_hi = rd_sel(32'(wa_hi), ctrl_q, en_o, balance_q, nodemap_q, pend_i,
                     route_o, lsel_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
      end else begin
         rvalid_o <= rd_en;
         if (rd_en) rdata_o <= {(wide ? rd_hi : 32'd0), rd_lo};
      end
   end

endmodule

// File: rtl/intr_pend.sv
module intr_pend #(
   parameter int unsigned NVEC = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NVEC-1:0] vec_i,
   input  logic [NVEC-1:0] clr_i,
   output logic [NVEC-1:0] rise_o,
   output logic [NVEC-1:0] pend_o
);

   logic [NVEC-1:0] vec_q;

   assign rise_o = vec_i & ~vec_q;

   // A new edge wins over a clear of the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q  <= '0;
         pend_o <= '0;
      end else begin
         vec_q  <= vec_i;
         pend_o <= (pend_o & ~clr_i) | rise_o;
      end
   end

endmodule

// File: rtl/intr_steer.sv
module intr_steer
   import intr_router_pkg::*;
#(
   parameter int unsigned NVEC    = 256,
   parameter int unsigned NCORE   = 4,
   parameter int unsigned NLINE   = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NVEC-1:0]                 pend_i,
   input  logic [NVEC-1:0]                 en_i,
   input  logic [NVEC*ROUTE_BITS-1:0]      route_i,
   input  logic [(NVEC/GROUP_SIZE)*LSEL_BITS-1:0] lsel_i,
   input  logic                            glb_en_i,
   input  logic                            cpu_enc_i,
   output logic [NCORE*NLINE-1:0]          irq_o
);

   localparam int unsigned OW = NCORE * NLINE;

   logic [OW-1:0] contrib [NVEC];
   logic [OW-1:0] merged;

   for (genvar v = 0; v < NVEC; v++) begin : g_vec
      logic [ROUTE_BITS-1:0] rb;
      logic [LSEL_BITS-1:0]  lb;
      logic [NCORE-1:0]      tgt_node;
      logic [NCORE-1:0]      tgt_cpu;
      logic [NCORE-1:0]      tgt;
      logic                  live;

      assign rb   = route_i[v*ROUTE_BITS +: ROUTE_BITS];
      assign lb   = lsel_i[(v/GROUP_SIZE)*LSEL_BITS +: LSEL_BITS];
      assign live = pend_i[v] & en_i[v] & glb_en_i;

      always_comb begin
         for (int c = 0; c < NCORE; c++) begin
            tgt_node[c] = (rb[7:4] == 4'd0) && rb[c];
            tgt_cpu[c]  = (rb == ROUTE_BITS'(c));
         end
      end

      assign tgt = live ? (cpu_enc_i ? tgt_cpu : tgt_node) : '0;

      for (genvar c = 0; c < NCORE; c++) begin : g_core
         assign contrib[v][c*NLINE +: NLINE] = tgt[c] ? lb[NLINE-1:0] : '0;
      end
   end

   always_comb begin
      merged = '0;
      for (int v = 0; v < NVEC; v++) merged = merged | contrib[v];
   end

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= '0;
         else        irq_o <= merged;
      end
   end else begin : g_comb_out
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o = merged;
   end

endmodule

// File: rtl/intr_router_top.sv
module intr_router_top
   import intr_router_pkg::*;
#(
   parameter int unsigned NVEC    = 256,
   parameter int unsigned NCORE   = 4,
   parameter int unsigned NLINE   = 8,
   parameter int unsigned AW      = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NVEC-1:0]        vec_in,
   input  logic                   reg_wr,
   input  logic                   reg_rd,
   input  logic                   reg_wide,
   input  logic [AW-1:0]          reg_addr,
   input  logic [63:0]            reg_wdata,
   output logic [63:0]            reg_rdata,
   output logic                   reg_rvalid,
   output logic [NCORE*NLINE-1:0] core_irq
);

   localparam int unsigned NGRP = NVEC / GROUP_SIZE;

   if (NVEC != 128 && NVEC != 256) begin : g_bad_nvec
      $error("NVEC must be 128 or 256");
   end
   if (NCORE < 1 || NCORE > 4) begin : g_bad_ncore
      $error("NCORE must be 1..4");
   end
   if (NLINE < 1 || NLINE > LSEL_BITS) begin : g_bad_nline
      $error("NLINE must be 1..8");
   end
   if (AW < 13) begin : g_bad_aw
      $error("AW must be at least 13");
   end

   logic [NVEC-1:0]            pend_q;
   logic [NVEC-1:0]            pend_rise;
   logic [NVEC-1:0]            clr_mask;
   logic [NVEC-1:0]            en_q;
   logic [NVEC*ROUTE_BITS-1:0] route_q;
   logic [NGRP*LSEL_BITS-1:0]  lsel_q;
   logic                       glb_en;
   logic                       cpu_enc;

   intr_regs #(.NVEC(NVEC), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
      .wide(reg_wide), .addr(reg_addr), .wdata(reg_wdata),
      .pend_i(pend_q), .rdata_o(reg_rdata), .rvalid_o(reg_rvalid),
      .en_o(en_q), .route_o(route_q), .lsel_o(lsel_q),
      .glb_en_o(glb_en), .cpu_enc_o(cpu_enc), .clr_o(clr_mask));

   intr_pend #(.NVEC(NVEC)) u_pend (
      .clk(clk), .rst_n(rst_n), .vec_i(vec_in), .clr_i(clr_mask),
      .rise_o(pend_rise), .pend_o(pend_q));

   intr_steer #(.NVEC(NVEC), .NCORE(NCORE), .NLINE(NLINE), .OUT_REG(OUT_REG)) u_steer (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_q), .en_i(en_q),
      .route_i(route_q), .lsel_i(lsel_q), .glb_en_i(glb_en),
      .cpu_enc_i(cpu_enc), .irq_o(core_irq));

endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk #(
   parameter int unsigned NVEC    = 256,
   parameter int unsigned NOUT    = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NVEC-1:0] rise,
   input logic [NVEC-1:0] pend,
   input logic [NVEC-1:0] clr,
   input logic            glb_en,
   input logic            reg_rd,
   input logic            reg_rvalid,
   input logic [NOUT-1:0] core_irq
);

   // R1: every rising edge leaves its pending bit set
   p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((pend & $past(rise)) == $past(rise)));

   // R2: a clear without a coincident edge empties the bit
   p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr & ~rise)) |=> ((pend & $past(clr & ~rise)) == '0));

   // R2: a pending bit only falls when written with a one
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0));

   // R11: read data valid exactly one cycle after a read
   p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);
   p_norvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !reg_rvalid);

   // R8: global switch off silences every line
   if (OUT_REG) begin : g_gate_reg
      p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !glb_en |=> (core_irq == '0));
   end else begin : g_gate_comb
      p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !glb_en |-> (core_irq == '0));
   end

endmodule

bind intr_router_top intr_router_chk #(
   .NVEC(NVEC), .NOUT(NCORE*NLINE), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rise(pend_rise), .pend(pend_q),
   .clr(clr_mask), .glb_en(glb_en), .reg_rd(reg_rd),
   .reg_rvalid(reg_rvalid), .core_irq(core_irq)
);

// File: tb/intr_router_top_test.sv
module intr_router_top_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] vec_in = '0;
   logic         reg_wr = 1'b0;
   logic         reg_rd = 1'b0;
   logic         reg_wide = 1'b0;
   logic [15:0]  reg_addr = '0;
   logic [63:0]  reg_wdata = '0;
   logic [63:0]  reg_rdata;
   logic         reg_rvalid;
   logic [31:0]  core_irq;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 1'b0;

   always #5ns clk = ~clk;

   intr_router_top uut (
      .clk(clk), .rst_n(rst_n), .vec_in(vec_in), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wide(reg_wide), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .core_irq(core_irq));

   // ---------------- behavioural reference ----------------
   bit       m_pend [256];
   bit       m_en   [256];
   bit [7:0] m_rt   [256];
   bit [7:0] m_ls   [8];
   bit       m_vprev[256];
   bit       m_gen;
   bit       m_cpu;
   bit [31:0] m_out;

   task automatic m_write(input int wa, input bit [31:0] d);
      if (wa == 'h400) begin
         m_gen = d[0];
         m_cpu = d[1];
      end else if (wa >= 'h580 && wa < 'h588) begin
         for (int b = 0; b < 32; b++) m_en[(wa - 'h580)*32 + b] = d[b];
      end else if (wa >= 'h600 && wa < 'h608) begin
         for (int b = 0; b < 32; b++) if (d[b]) m_pend[(wa - 'h600)*32 + b] = 1'b0;
      end else if (wa >= 'h700 && wa < 'h740) begin
         for (int k = 0; k < 4; k++) m_rt[(wa - 'h700)*4 + k] = d[8*k +: 8];
      end else if (wa >= 'h530 && wa < 'h532) begin
         for (int k = 0; k < 4; k++) m_ls[(wa - 'h530)*4 + k] = d[8*k +: 8];
      end
   endtask

   function automatic bit [31:0] m_calc();
      bit [31:0] o;
      o = '0;
      for (int v = 0; v < 256; v++) begin
         if (m_pend[v] && m_en[v] && m_gen) begin
            for (int c = 0; c < 4; c++) begin
               bit hit;
               hit = m_cpu ? (int'(m_rt[v]) == c)
                           : (m_rt[v][7:4] == 4'd0 && m_rt[v][c]);
               if (hit) o[c*8 +: 8] = o[c*8 +: 8] | m_ls[v/32];
            end
         end
      end
      return o;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int v = 0; v < 256; v++) begin
            m_pend[v] = 0; m_en[v] = 0; m_rt[v] = 0; m_vprev[v] = 0;
         end
         for (int g = 0; g < 8; g++) m_ls[g] = 0;
         m_gen = 0; m_cpu = 0; m_out = 0;
      end else begin : m_step
         bit [31:0] nxt;
         nxt = m_calc();
         if (reg_wr) begin
            m_write(int'(reg_addr[15:2]), reg_wdata[31:0]);
            if (reg_wide) m_write(int'(reg_addr[15:2]) + 1, reg_wdata[63:32]);
         end
         for (int v = 0; v < 256; v++) begin
            if (vec_in[v] && !m_vprev[v]) m_pend[v] = 1'b1;
            m_vprev[v] = vec_in[v];
         end
         m_out = nxt;
      end
   end

   // Every-cycle comparison of the lines against the reference (R9)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (core_irq !== m_out) begin
            n_err++;
            $display("FAIL R9 lines (%s form) actual %h expected %h",
                     m_cpu ? "R6" : "R5", core_irq, m_out);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input bit [63:0] act, input bit [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit [15:0] a, input bit [63:0] d, input bit w);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = w;
      @(negedge clk);
      reg_wr = 1'b0; reg_wide = 1'b0;
   endtask

   task automatic rd(input string tag, input bit [15:0] a, input bit w,
                     input bit [63:0] exp);
      reg_rd = 1'b1; reg_addr = a; reg_wide = w;
      @(negedge clk);
      reg_rd = 1'b0; reg_wide = 1'b0;
      chk({tag, " rvalid R11"}, 64'(reg_rvalid), 64'd1);
      chk(tag, reg_rdata, exp);
   endtask

   task automatic wait2();
      @(negedge clk); @(negedge clk);
   endtask

   initial begin : watchdog
      #2ms;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 lines", 64'(core_irq), 64'd0);
      rd("R12 enable", 16'h1600, 1'b0, 64'd0);
      rd("R12 route", 16'h1C00, 1'b0, 64'd0);
      rd("R12 control", 16'h1000, 1'b0, 64'd0);

      // R1 latch while disabled; R8 silent output
      vec_in[5] = 1'b1; @(negedge clk); vec_in[5] = 1'b0;
      rd("R1 status word0", 16'h1800, 1'b0, 64'h20);
      chk("R8 lines while off", 64'(core_irq), 64'd0);

      // R1 held level, R2 64-bit clear
      vec_in[40] = 1'b1; @(negedge clk);
      rd("R2 status 64-bit", 16'h1800, 1'b1, 64'h0000_0100_0000_0020);
      wr(16'h1800, 64'h0000_0100_0000_0000, 1'b1);
      repeat (3) @(negedge clk);
      rd("R1 held level no reset", 16'h1800, 1'b1, 64'h20);
      wr(16'h1800, 64'h0, 1'b0);
      rd("R2 write zero keeps", 16'h1800, 1'b0, 64'h20);
      vec_in[40] = 1'b0;

      // R3 R4 R7 configuration, R9 latency
      wr(16'h14C0, 64'h0000_0004, 1'b0);
      wr(16'h1C04, 64'h0000_0200, 1'b0);
      wr(16'h1600, 64'h0000_0020, 1'b0);
      wait2();
      chk("R8 configured but off", 64'(core_irq), 64'd0);
      wr(16'h1000, 64'h1, 1'b0);
      chk("R9 one cycle latency", 64'(core_irq), 64'd0);
      @(negedge clk);
      chk("R5 R7 core1 line2", 64'(core_irq), 64'h0000_0400);
      wr(16'h1000, 64'h0, 1'b0);
      @(negedge clk);
      chk("R8 switch off", 64'(core_irq), 64'd0);
      rd("R8 pending kept", 16'h1800, 1'b0, 64'h20);

      // R5 default form corners
      wr(16'h1000, 64'h1, 1'b0);
      wr(16'h1C04, 64'h0000_1200, 1'b0);
      wait2();
      chk("R5 nonzero node", 64'(core_irq), 64'd0);
      wr(16'h1C04, 64'h0000_0000, 1'b0);
      wait2();
      chk("R5 zero mask", 64'(core_irq), 64'd0);
      wr(16'h1C04, 64'h0000_0A00, 1'b0);
      wait2();
      chk("R5 two cores", 64'(core_irq), 64'h0400_0400);
      wr(16'h1600, 64'h0, 1'b0);
      wait2();
      chk("R3 disabled vector", 64'(core_irq), 64'd0);
      wr(16'h1600, 64'h20, 1'b0);

      // R6 binary core index
      wr(16'h1000, 64'h3, 1'b0);
      wr(16'h1C04, 64'h0000_0300, 1'b0);
      wait2();
      chk("R6 index 3", 64'(core_irq), 64'h0400_0000);
      wr(16'h1C04, 64'h0000_0900, 1'b0);
      wait2();
      chk("R6 index out of range", 64'(core_irq), 64'd0);
      wr(16'h1C04, 64'h0000_0000, 1'b0);
      wait2();
      chk("R6 index 0", 64'(core_irq), 64'h0000_0004);

      // R4 R7 R11 highest vector, top group, 64-bit write
      vec_in[255] = 1'b1; @(negedge clk); vec_in[255] = 1'b0;
      wr(16'h14C4, 64'h8000_0000, 1'b0);
      wr(16'h1CFC, 64'h0200_0000, 1'b0);
      wr(16'h1618, 64'h8000_0000_0000_0000, 1'b1);
      wait2();
      chk("R4 R7 vector 255", 64'(core_irq), 64'h0080_0004);
      rd("R11 64-bit enable", 16'h1618, 1'b1, 64'h8000_0000_0000_0000);
      rd("R2 status word3", 16'h1818, 1'b1, 64'h8000_0000_0000_0000);

      // R10 storage banks without effect, R11 unmapped
      wr(16'h14A0, 64'hFFFF_FFFF, 1'b0);
      wr(16'h1680, 64'hFFFF_FFFF, 1'b0);
      wait2();
      chk("R10 no effect", 64'(core_irq), 64'h0080_0004);
      rd("R10 node map", 16'h14A0, 1'b0, 64'hFFFF_FFFF);
      rd("R10 balance", 16'h1680, 1'b0, 64'hFFFF_FFFF);
      rd("R11 unmapped", 16'h0100, 1'b0, 64'd0);

      // R2 edge coinciding with clear of the same bit
      vec_in[7] = 1'b1;
      wr(16'h1800, 64'h80, 1'b0);
      vec_in[7] = 1'b0;
      rd("R2 edge beats clear", 16'h1800, 1'b0, 64'hA0);

      // R3 nothing pending, nothing driven
      wr(16'h1800, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
      wr(16'h1818, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
      wait2();
      chk("R3 all cleared", 64'(core_irq), 64'd0);
      rd("R2 status empty", 16'h1800, 1'b1, 64'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule